// File: doc/BRIEF.md
# Single-Precision Register Format Converter

This block rearranges floating-point and integer bit images between a 32-bit memory word and a 64-bit register word. A *load* widens a single-precision word into a register image. That image uses an 11-bit exponent field. The exponent is widened by steering bits according to the top exponent bit, with no bias arithmetic. A *store* folds a register image back into the 32-bit word. A *pack* places a 64-bit integer into the layout used for a 32-bit integer held in a floating-point register. The pack also flags when the integer does not fit in 32 signed bits.

The block performs no rounding and no arithmetic. Every conversion is pure bit steering plus one overflow comparison. The converter sits on a valid/ready stream with a single output register stage. An input word is taken on any cycle where `in_valid` and `in_ready` are both high, and its result appears on the output one cycle later. A result that is not yet taken holds still. `in_ready` stays high whenever the output register is empty or is being emptied in the same cycle. Back-pressure from `out_ready` therefore reaches the input combinationally, with no extra buffering.

Top module: `fmtcvt_unit`

## Requirements
- R1: With `in_op` = 2'b00 (load), `out_data[63]` equals `in_data[31]`, `out_data[51:29]` equals `in_data[22:0]`, and `out_data[28:0]` is zero.
- R2: In a load, input bit 30 becomes `out_data[62]` (bit 10 of the wide exponent) and input bits 29:23 become `out_data[58:52]`. When input bit 30 is 1, bits 61:59 are zero, except that when input bits 29:23 are all ones the whole wide exponent `out_data[62:52]` is 11'h7FF.
- R3: In a load with input bit 30 at 0, `out_data[61:59]` are ones when input bits 29:23 are nonzero. When input bits 29:23 are zero, the wide exponent is 11'h000.
- R4: With `in_op` = 2'b01 (store), `out_data[31:30]` equals `in_data[63:62]`, `out_data[29:0]` equals `in_data[58:29]`, and `out_data[63:32]` is zero.
- R5: With `in_op` = 2'b10 (pack), `out_data[63:62]` equals `in_data[31:30]` and `out_data[58:29]` equals `in_data[29:0]`. All other output bits are zero.
- R6: A pack raises both `out_iov` and `out_ine` exactly when `in_data` differs from the sign extension of `in_data[31:0]`. Every other operation leaves both flags low.
- R7: `in_op` = 2'b11 is reserved. It produces an all-zero `out_data` with both flags low.
- R8: A load of any 32-bit word, followed by a store of the load result, returns the original word in `out_data[31:0]`.
- R9: An input is accepted when `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` high on the next cycle. While `out_valid` is high and `out_ready` is low, the output and flags hold. `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R10: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Converter can take the input word |
| in_op | input | 2 | 00 load, 01 store, 10 pack, 11 reserved |
| in_data | input | 64 | Source word (load uses bits 31:0) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Converted word |
| out_iov | output | 1 | Integer overflow on pack |
| out_ine | output | 1 | Inexact on pack |

## Verification
The only state is the output register: the result word, its two flags and the valid bit. A wrong latch shows at `out_data` or on the flags on the very next cycle after acceptance. A valid bit that is stuck or dropped shows within one cycle, either as a lost or duplicated result in the scoreboard order or as `in_ready` low while the stage is empty. Random stalls on `out_ready` make any drift of a held result visible at the next falling clock edge. Exponent remapping corner words are driven explicitly, and a load-then-store round trip catches any asymmetry between the two directions.

// File: rtl/fmtcvt_pkg.sv
package fmtcvt_pkg;
  localparam int REG_W    = 64;
  localparam int MEM_W    = 32;
  localparam int WEXP_W   = 11;
  localparam int NEXP_W   = 8;
  localparam int FRAC_W   = 23;
  localparam int PAD_W    = REG_W - 1 - WEXP_W - FRAC_W;
  localparam int NLOW_W   = NEXP_W - 1;
  localparam int FILL_W   = WEXP_W - NEXP_W;
  localparam int BODY_W   = MEM_W - 2;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_PACK  = 2'b10,
    OP_RSVD  = 2'b11
  } cvt_op_e;

  typedef struct packed {
    logic [REG_W-1:0] data;
    logic             iov;
    logic             ine;
  } cvt_res_t;
endpackage

// File: rtl/sp_expand.sv
module sp_expand
  import fmtcvt_pkg::*;
(
  input  logic [MEM_W-1:0] word_i,
  output logic [REG_W-1:0] reg_o
);
  logic             sgn;
  logic             emsb;
  logic [NLOW_W-1:0] elow;
  logic [FRAC_W-1:0] frac;
  logic [WEXP_W-1:0] wexp;

  assign sgn  = word_i[MEM_W-1];
  assign emsb = word_i[MEM_W-2];
  assign elow = word_i[MEM_W-3 -: NLOW_W];
  assign frac = word_i[FRAC_W-1:0];

  always_comb begin
    if (emsb) begin
      if (&elow) wexp = {WEXP_W{1'b1}};
      else       wexp = {1'b1, {FILL_W{1'b0}}, elow};
    end else begin
      if (|elow) wexp = {1'b0, {FILL_W{1'b1}}, elow};
      else       wexp = '0;
    end
  end

  assign reg_o = {sgn, wexp, frac, {PAD_W{1'b0}}};
endmodule

// File: rtl/sp_compress.sv
module sp_compress
  import fmtcvt_pkg::*;
(
  input  logic [1:0]        top_i,
  input  logic [BODY_W-1:0] body_i,
  output logic [REG_W-1:0]  reg_o
);
  assign reg_o = {{(REG_W-MEM_W){1'b0}}, top_i, body_i};
endmodule

// File: rtl/lw_pack.sv
module lw_pack
  import fmtcvt_pkg::*;
(
  input  logic [REG_W-1:0] val_i,
  output logic [REG_W-1:0] reg_o,
  output logic             ovf_o
);
  localparam int GAP_W = REG_W - 2 - BODY_W - PAD_W;

  logic [REG_W-MEM_W:0] upper;

  assign reg_o = {val_i[MEM_W-1 -: 2], {GAP_W{1'b0}}, val_i[BODY_W-1:0], {PAD_W{1'b0}}};
  assign upper = val_i[REG_W-1:MEM_W-1];
  assign ovf_o = !((&upper) || !(|upper));
endmodule

// File: rtl/fmtcvt_unit.sv
module fmtcvt_unit
  import fmtcvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [REG_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [REG_W-1:0]  out_data,
  output logic              out_iov,
  output logic              out_ine
);
  logic [REG_W-1:0] ld_w, st_w, pk_w;
  logic             pk_ovf;
  cvt_op_e          op;
  cvt_res_t         nxt, cur;
  logic             take;

  sp_expand u_exp (
    .word_i (in_data[MEM_W-1:0]),
    .reg_o  (ld_w)
  );

  sp_compress u_cmp (
    .top_i  (in_data[REG_W-1 -: 2]),
    .body_i (in_data[REG_W-1-1-WEXP_W+NLOW_W -: BODY_W]),
    .reg_o  (st_w)
  );

  lw_pack u_pck (
    .val_i (in_data),
    .reg_o (pk_w),
    .ovf_o (pk_ovf)
  );

  assign op = cvt_op_e'(in_op);

  always_comb begin
    nxt = '0;
    unique case (op)
      OP_LOAD:  nxt.data = ld_w;
      OP_STORE: nxt.data = st_w;
      OP_PACK: begin
        nxt.data = pk_w;
        nxt.iov  = pk_ovf;
        nxt.ine  = pk_ovf;
      end
      default:  nxt = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cur       <= '0;
    end else begin
      if (take) begin
        cur       <= nxt;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_data = cur.data;
  assign out_iov  = cur.iov;
  assign out_ine  = cur.ine;
endmodule

// File: rtl/fmtcvt_unit_chk.sv
module fmtcvt_unit_chk
  import fmtcvt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_op,
  input logic             out_valid,
  input logic             out_ready,
  input logic [REG_W-1:0] out_data,
  input logic             out_iov,
  input logic             out_ine
);
  logic [1:0] op_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    op_q <= OP_LOAD;
    else if (in_valid && in_ready) op_q <= in_op;
  end

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R9
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_iov) && $stable(out_ine)); // R9
  AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_iov == out_ine); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q != OP_PACK |-> !out_iov && !out_ine); // R6
  AST_LOAD_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q == OP_LOAD |-> out_data[28:0] == '0); // R1
  AST_STORE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q == OP_STORE |-> out_data[63:32] == '0); // R4
  AST_PACK_GAPS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q == OP_PACK |-> out_data[61:59] == '0 && out_data[28:0] == '0); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q == OP_RSVD |-> out_data == '0); // R7
endmodule

bind fmtcvt_unit fmtcvt_unit_chk u_chk (.*);

// File: tb/sim_fmtcvt_unit.sv
`timescale 1ns/1ps
module sim_fmtcvt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_iov, out_ine;

  int checks = 0;
  int fails  = 0;
  bit bp_on  = 1'b0;
  bit done   = 1'b0;

  logic [63:0] q_data[$];
  logic        q_flag[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  fmtcvt_unit u0 (.*);

  function automatic logic [63:0] m_load(input logic [31:0] w);
    logic [10:0] e;
    case ({w[30], (w[29:23] == 7'h7f), (w[29:23] == 7'h00)})
      3'b110:  e = 11'h7ff;
      3'b100, 3'b101: e = {4'b1000, w[29:23]};
      3'b001:  e = 11'h000;
      default: e = {4'b0111, w[29:23]};
    endcase
    return {w[31], e, w[22:0], 29'h0};
  endfunction

  function automatic logic [63:0] m_store(input logic [63:0] r);
    return {32'h0, r[63:62], r[58:29]};
  endfunction

  function automatic logic [63:0] m_pack(input logic [63:0] v);
    return {v[31:30], 3'b000, v[29:0], 29'h0};
  endfunction

  function automatic logic m_ovf(input logic [63:0] v);
    return $signed(v) != $signed({{32{v[31]}}, v[31:0]});
  endfunction

  task automatic send(input logic [1:0] op, input logic [63:0] d,
                      input logic [63:0] xd, input logic xf, input string tag);
    in_valid = 1'b1; in_op = op; in_data = d;
    do @(negedge clk); while (!in_ready);
    q_data.push_back(xd); q_flag.push_back(xf); q_tag.push_back(tag);
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic do_load(input logic [31:0] w);
    send(2'b00, {32'hdead_beef, w}, m_load(w), 1'b0, "R1/R2/R3 load");
  endtask
  task automatic do_store(input logic [63:0] r);
    send(2'b01, r, m_store(r), 1'b0, "R4 store");
  endtask
  task automatic do_pack(input logic [63:0] v);
    send(2'b10, v, m_pack(v), m_ovf(v), "R5/R6 pack");
  endtask
  task automatic do_trip(input logic [31:0] w);
    send(2'b00, {32'h0, w}, m_load(w), 1'b0, "R8 trip-load");
    send(2'b01, m_load(w), {32'h0, w}, 1'b0, "R8 round trip");
  endtask

  always @(posedge clk) begin
    #2;
    out_ready = bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  bit          held = 1'b0;
  logic [63:0] hdata;
  logic [1:0]  hflag;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        checks++;
        if (!out_valid || out_data !== hdata || {out_iov, out_ine} !== hflag) begin
          fails++;
          $display("FAIL R9 stall hold: got v=%0b %h %b exp v=1 %h %b",
                   out_valid, out_data, {out_iov, out_ine}, hdata, hflag);
        end
      end
      if (!out_valid) begin
        checks++;
        if (!in_ready) begin
          fails++;
          $display("FAIL R9 idle ready: got %0b exp 1", in_ready);
        end
      end
      held  = out_valid && !out_ready;
      hdata = out_data;
      hflag = {out_iov, out_ine};
      if (out_valid && out_ready) begin
        checks++;
        if (q_data.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected output: got %h exp none", out_data);
        end else begin
          logic [63:0] xd;
          logic        xf;
          string       tg;
          xd = q_data.pop_front(); xf = q_flag.pop_front(); tg = q_tag.pop_front();
          if (out_data !== xd || out_iov !== xf || out_ine !== xf) begin
            fails++;
            $display("FAIL %s: got %h iov=%b ine=%b exp %h flags=%b",
                     tg, out_data, out_iov, out_ine, xd, xf);
          end
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 reset: got valid=%b ready=%b exp 0 1", out_valid, in_ready);
    end
    @(posedge clk); #1; rst_n = 1'b1; #1;

    // R2/R3 exponent corners
    do_load(32'h0000_0000);
    do_load(32'h8000_0000);
    do_load(32'h0080_0001);
    do_load(32'h3f80_0000);
    do_load(32'h3fff_ffff);
    do_load(32'h4000_0000);
    do_load(32'h7f80_0000);
    do_load(32'hffc0_0001);
    do_load(32'h7f7f_ffff);
    // R4
    do_store(64'hc7ff_ffff_e000_0000);
    do_store(64'h3800_0000_2000_0000);
    // R5/R6 pack boundaries
    do_pack(64'h0000_0000_7fff_ffff);
    do_pack(64'hffff_ffff_8000_0000);
    do_pack(64'h0000_0000_8000_0000);
    do_pack(64'hffff_ffff_7fff_ffff);
    do_pack(64'h0000_0001_0000_0000);
    do_pack(64'hffff_ffff_ffff_ffff);
    // R7 reserved
    send(2'b11, 64'hffff_ffff_ffff_ffff, 64'h0, 1'b0, "R7 reserved");
    send(2'b11, 64'h1234_5678_9abc_def0, 64'h0, 1'b0, "R7 reserved");

    bp_on = 1'b1;
    for (int i = 0; i < 1200; i++) begin
      logic [31:0] w;
      logic [63:0] v;
      w = $urandom;
      v = {$urandom, $urandom};
      do_load(w);
      do_trip(w);
      do_store(v);
      if (i % 2 == 0) do_pack({{32{w[31]}}, w});
      else            do_pack(v);
    end
    bp_on = 1'b0;
    while (q_data.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule